// File: doc/BRIEF.md
# Multiplexed Slave Bus Access Controller

This block connects an internal requester to up to four external slave devices over a shared 16-bit bus. The same 16 wires carry the address first and then the data. A request is a single-cycle strobe that carries an address, a direction and write data. The controller decodes the upper address bits to pick one slave, whose 1 MB window is fixed. It then runs a fixed phase sequence on the bus: address, wait, data, recovery and idle.

The address phase puts the slave-local 16-bit address on the bus and raises an address-latch strobe for one cycle. For a write, the data phase drives the write data. For a read, the drivers are released so the slave can drive the bus. The controller then waits for the slave's active-low ready. If ready never arrives within a parameterised number of data-phase cycles, the access is aborted and reported as an error. Only one access is in flight at a time. A busy flag tells the requester when a new request can be taken.

Top module: `mxbus_ctrl`

## Requirements
- R1: Address bits [23:20] select the slave. Region value SLV_BASE+i (default 4..7) drives chip select bit i low. No other chip select is low. The select is held low only during the address, wait and data phases.
- R2: A request whose region matches no slave causes no chip select and no latch strobe. Busy is high for exactly one cycle, and that cycle carries a response with error=1 and read data 0.
- R3: In the first cycle of an access, the latch strobe is high for exactly one cycle. The bus drivers are enabled and carry request address bits [15:0]. Address bits [19:16] do not reach the bus, so they alias within the window.
- R4: The write/not-read line is 1 for a write and 0 for a read. It holds that value for the whole time the chip select is low.
- R5: During the wait and data phases of a write, the drivers are enabled and carry the request write data unchanged. Data bits [7:0], the lower-addressed byte, sit on bus lines [7:0].
- R6: During the wait and data phases of a read, the drivers are disabled. The response read data is the bus input value sampled at the clock edge where ready is seen low.
- R7: Ready is sampled only in the data phase, and a high ready line extends that phase. Busy therefore lasts 3 + D cycles, where D is the number of data-phase cycles, and D is at least 1.
- R8: If ready stays high for TMO_CYC data-phase cycles, the access ends with error=1 and read data 0. Ready seen low in the last permitted cycle completes the access without error.
- R9: Busy rises in the cycle after a request is accepted and stays high through the recovery phase. The response valid flag pulses for exactly the last busy cycle, and busy is low afterwards.
- R10: A request presented while busy is high is ignored. It produces no bus access and no response.
- R11: In the recovery phase all chip selects are high, the drivers are disabled and the latch strobe is low. A new access cannot start before one further idle cycle has passed, so at least two cycles with no chip select separate two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all outputs change and all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Single-cycle request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Requester byte address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Unmapped address or timeout |
| rsp_rdata | output | 16 | Read data, 0 on error or write |
| bus_cs_n | output | 4 | Active-low slave chip selects |
| bus_ale | output | 1 | Address latch strobe |
| bus_wnr | output | 1 | Write/not-read indication |
| bus_ad_out | output | 16 | Multiplexed address/data driven value |
| bus_ad_oe | output | 1 | Driver enable for bus_ad_out |
| bus_ad_in | input | 16 | Multiplexed bus value driven by the slave |
| bus_rdy_n | input | 1 | Active-low ready from the slave, high when idle |

## Verification
The bench builds the controller with TMO_CYC=8 and keeps the default base region of 4 with four slaves. The short timeout lets randomly drawn slave latencies of 0 to 11 cycles land on both sides of the limit. That includes ready arriving in exactly the last permitted cycle, which a 256-cycle default would make slow to reach. The unmapped regions on both sides of the window, the aliased upper window bits, requests issued during busy and back-to-back accesses are added as directed cases.

// File: rtl/mxbus_pkg.sv
// Shared types for the multiplexed slave bus controller.
// Assumes nothing beyond standard SystemVerilog packages.
package mxbus_pkg;

    // Bus phase of the access sequencer; PH_TI is also the idle state.
    typedef enum logic [2:0] {
        PH_TI = 3'd0,
        PH_TA = 3'd1,
        PH_TW = 3'd2,
        PH_TD = 3'd3,
        PH_TR = 3'd4
    } phase_t;

endpackage

// File: rtl/mxbus_decode.sv
// Region decoder: maps the upper requester address bits onto one of
// N_SLV fixed windows. Assumes windows SLV_BASE..SLV_BASE+N_SLV-1
// fit inside the region field.
module mxbus_decode #(
    parameter int ADDR_W   = 24,
    parameter int WIN_W    = 20,
    parameter int N_SLV    = 4,
    parameter int SLV_BASE = 4,
    localparam int SEL_W   = (N_SLV > 1) ? $clog2(N_SLV) : 1,
    localparam int REG_W   = ADDR_W - WIN_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEL_W-1:0]  sel
);

    logic [REG_W-1:0] region;
    logic [N_SLV-1:0] match;

    assign region = addr[ADDR_W-1:WIN_W];

    // One comparator per slave window.
    for (genvar i = 0; i < N_SLV; i++) begin : g_win
        assign match[i] = (region == REG_W'(SLV_BASE + i));
    end

    assign hit = |match;

    // Encode the matching window into a slave index.
    always_comb begin
        sel = '0;
        for (int k = 0; k < N_SLV; k++) begin
            if (match[k]) sel = SEL_W'(k);
        end
    end

endmodule

// File: rtl/mxbus_tmo.sv
// Data-phase watchdog: counts cycles while run is high and flags the
// last permitted cycle. Assumes TMO_CYC >= 2 and that run drops once
// expire has been seen.
module mxbus_tmo #(
    parameter int TMO_CYC = 256,
    localparam int CNT_W  = $clog2(TMO_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] cnt;

    // Count data-phase cycles; clear whenever the phase is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(TMO_CYC - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == CNT_W'(TMO_CYC - 1));

    // R8: the counter never runs past the permitted window.
    assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) < TMO_CYC);

endmodule

// File: rtl/mxbus_seq.sv
// Access sequencer: captures one request, walks the address, wait,
// data, recovery and idle phases, and drives the multiplexed bus.
// Assumes ready and bus input data are synchronous to clk.
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int N_SLV  = 4,
    localparam int SEL_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_offs,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_hit,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic              tmo_expire,
    output logic              td_run,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [N_SLV-1:0]  bus_cs_n,
    output logic              bus_ale,
    output logic              bus_wnr,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    input  logic              bus_rdy_n
);

    phase_t            ph;
    logic              wr_q;
    logic              err_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] offs_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              act;

    // Phase sequencer with request capture, ready wait and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_TI;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            sel_q   <= '0;
            offs_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (ph)
                PH_TI: begin
                    if (req_valid) begin
                        wr_q    <= req_write & req_hit;
                        err_q   <= ~req_hit;
                        sel_q   <= req_sel;
                        offs_q  <= req_offs;
                        wdata_q <= req_wdata;
                        rdata_q <= '0;
                        ph      <= req_hit ? PH_TA : PH_TR;
                    end
                end
                PH_TA: ph <= PH_TW;
                PH_TW: ph <= PH_TD;
                PH_TD: begin
                    if (!bus_rdy_n) begin
                        if (!wr_q) rdata_q <= bus_ad_in;
                        ph <= PH_TR;
                    end else if (tmo_expire) begin
                        err_q <= 1'b1;
                        ph    <= PH_TR;
                    end
                end
                PH_TR:   ph <= PH_TI;
                default: ph <= PH_TI;
            endcase
        end
    end

    assign act    = (ph == PH_TA) || (ph == PH_TW) || (ph == PH_TD);
    assign td_run = (ph == PH_TD);

    // One chip select per slave, low only while this slave is addressed.
    for (genvar i = 0; i < N_SLV; i++) begin : g_cs
        assign bus_cs_n[i] = !(act && (sel_q == SEL_W'(i)));
    end

    assign bus_ale    = (ph == PH_TA);
    assign bus_wnr    = act && wr_q;
    assign bus_ad_oe  = (ph == PH_TA) || (((ph == PH_TW) || (ph == PH_TD)) && wr_q);
    assign bus_ad_out = (ph == PH_TA) ? offs_q : wdata_q;

    assign busy      = (ph != PH_TI);
    assign rsp_valid = (ph == PH_TR);
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

    // R1: at most one slave selected at any time.
    assert_one_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    // R3: latch strobe lasts a single cycle.
    assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    // R3: latch strobe only with a selected slave and driven bus.
    assert_ale_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> ((bus_cs_n != '1) && bus_ad_oe));

    // R4: direction is stable while a slave stays selected.
    assert_wnr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cs_n != '1) && $past(bus_cs_n != '1)) |-> $stable(bus_wnr));

    // R6: drivers released during a read's wait and data phases.
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cs_n != '1) && !bus_ale && !bus_wnr) |-> !bus_ad_oe);

    // R8: an errored response carries zero data.
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R9: the response ends the busy period.
    assert_rsp_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);

    // R11: recovery releases selects and drivers.
    assert_tr_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((bus_cs_n == '1) && !bus_ad_oe && !bus_ale));

endmodule

// File: rtl/mxbus_ctrl.sv
// Multiplexed slave bus access controller top: region decode, access
// sequencer and data-phase watchdog. Assumes one outstanding access and
// a slave-local address no wider than the data bus.
module mxbus_ctrl #(
    parameter int ADDR_W   = 24,
    parameter int WIN_W    = 20,
    parameter int DATA_W   = 16,
    parameter int N_SLV    = 4,
    parameter int SLV_BASE = 4,
    parameter int TMO_CYC  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [N_SLV-1:0]  bus_cs_n,
    output logic              bus_ale,
    output logic              bus_wnr,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    input  logic              bus_rdy_n
);

    localparam int SEL_W  = (N_SLV > 1) ? $clog2(N_SLV) : 1;
    localparam int SLV_AW = DATA_W;

    logic             dec_hit;
    logic [SEL_W-1:0] dec_sel;
    logic             td_run;
    logic             tmo_expire;
    logic             unused_alias_bits;

    // Window bits above the slave-local range alias and are dropped.
    assign unused_alias_bits = ^req_addr[WIN_W-1:SLV_AW];

    mxbus_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_W   (WIN_W),
        .N_SLV   (N_SLV),
        .SLV_BASE(SLV_BASE)
    ) u_decode (
        .addr(req_addr),
        .hit (dec_hit),
        .sel (dec_sel)
    );

    mxbus_tmo #(
        .TMO_CYC(TMO_CYC)
    ) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (td_run),
        .expire(tmo_expire)
    );

    mxbus_seq #(
        .DATA_W(DATA_W),
        .N_SLV (N_SLV)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_offs  (req_addr[SLV_AW-1:0]),
        .req_wdata (req_wdata),
        .req_hit   (dec_hit),
        .req_sel   (dec_sel),
        .tmo_expire(tmo_expire),
        .td_run    (td_run),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_cs_n  (bus_cs_n),
        .bus_ale   (bus_ale),
        .bus_wnr   (bus_wnr),
        .bus_ad_out(bus_ad_out),
        .bus_ad_oe (bus_ad_oe),
        .bus_ad_in (bus_ad_in),
        .bus_rdy_n (bus_rdy_n)
    );

endmodule

// File: tb/mxbus_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for mxbus_ctrl: a latency-programmable slave model plus a bus
// monitor, random and directed accesses, expectations from functions.
module mxbus_ctrl_bench;

    localparam int TMO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic [3:0]  bus_cs_n;
    logic        bus_ale, bus_wnr, bus_ad_oe;
    logic [15:0] bus_ad_out;
    logic [15:0] bus_ad_in = 16'hDEAD;
    logic        bus_rdy_n = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Slave model and monitor state.
    int          lat_g = 0;
    int          scnt = 0;
    logic [15:0] exp_w = '0;
    int          ale_cnt, busy_cnt, rsp_cnt, gap, last_gap;
    bit          cs_seen, cs_bad, wnr_bad, wd_bad, rd_bad, tr_bad, obs_err;
    logic [15:0] obs_addr, obs_rdata;
    logic [3:0]  obs_cs;
    logic        obs_wnr, obs_oe_ta;

    always #2.5 clk = ~clk;

    mxbus_ctrl #(.TMO_CYC(TMO)) u_mxbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_wnr(bus_wnr),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_rdy_n(bus_rdy_n)
    );

    function automatic logic [15:0] rd_pat(int idx, logic [15:0] a);
        return a ^ 16'h3C5A ^ 16'(idx << 12);
    endfunction

    function automatic int cs_idx(logic [3:0] cs);
        for (int k = 0; k < 4; k++) if (!cs[k]) return k;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_obs();
        ale_cnt = 0; busy_cnt = 0; rsp_cnt = 0;
        cs_seen = 0; cs_bad = 0; wnr_bad = 0; wd_bad = 0; rd_bad = 0; tr_bad = 0;
        obs_err = 0; obs_rdata = '0; obs_addr = '0; obs_cs = 4'hF;
        obs_wnr = 0; obs_oe_ta = 0;
    endtask

    // Slave response and bus observation, once per falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cs_n != 4'hF) begin
                if (gap >= 0) begin last_gap = gap; gap = -1; end
                cs_seen = 1;
                if (bus_ale) begin
                    ale_cnt++;
                    obs_addr = bus_ad_out; obs_cs = bus_cs_n;
                    obs_wnr = bus_wnr; obs_oe_ta = bus_ad_oe;
                end else begin
                    scnt++;
                    if (bus_wnr && !(bus_ad_oe && bus_ad_out == exp_w)) wd_bad = 1;
                    if (!bus_wnr && bus_ad_oe) rd_bad = 1;
                end
                if (bus_wnr != obs_wnr) wnr_bad = 1;
                if (bus_cs_n != obs_cs) cs_bad = 1;
                if (scnt >= lat_g) begin
                    bus_rdy_n = 1'b0;
                    bus_ad_in = rd_pat(cs_idx(bus_cs_n), obs_addr);
                end else begin
                    bus_rdy_n = 1'b1; bus_ad_in = 16'hDEAD;
                end
            end else begin
                if (gap < 0) gap = 0;
                gap++;
                scnt = 0; bus_rdy_n = 1'b1; bus_ad_in = 16'hDEAD;
            end
            if (busy) busy_cnt++;
            if (rsp_valid) begin
                rsp_cnt++; obs_err = rsp_err; obs_rdata = rsp_rdata;
                if (bus_cs_n != 4'hF || bus_ad_oe || bus_ale) tr_bad = 1;
            end
        end
    end

    task automatic access(logic [23:0] a, bit wr, logic [15:0] wd, int lat, bit poke);
        int guard;
        int region, idx, tdl, td, exp_busy;
        bit mapped, to;
        logic [15:0] exp_rd;
        clr_obs();
        lat_g = lat; exp_w = wd;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk); #1;
        req_valid = 0;
        if (poke) begin
            @(negedge clk); #1;
            req_valid = 1; req_write = ~wr; req_addr = {4'd5, 20'h00042};
            @(negedge clk); #1;
            req_valid = 0;
        end
        guard = 0;
        while (busy && guard < 4 * TMO + 20) begin @(negedge clk); #1; guard++; end

        region = int'(a[23:20]);
        mapped = (region >= 4 && region <= 7);
        idx = region - 4;
        if (!mapped) begin
            chk(!cs_seen, "R2 no chip select", cs_seen, 0);
            chk(ale_cnt == 0, "R2 no latch strobe", ale_cnt, 0);
            chk(busy_cnt == 1, "R2 busy length", busy_cnt, 1);
            chk(rsp_cnt == 1 && obs_err, "R2 error response", obs_err, 1);
            chk(obs_rdata == 0, "R2 zero data", obs_rdata, 0);
        end else begin
            tdl = (lat <= 1) ? 1 : lat - 1;
            to = (tdl > TMO);
            td = to ? TMO : tdl;
            exp_busy = 3 + td;
            exp_rd = (!wr && !to) ? rd_pat(idx, a[15:0]) : 16'h0;
            chk(obs_cs == ~(4'b1 << idx) && !cs_bad, "R1 chip select", obs_cs, ~(4'b1 << idx));
            chk(ale_cnt == 1, "R3 one latch strobe", ale_cnt, 1);
            chk(obs_addr == a[15:0] && obs_oe_ta, "R3 address phase", obs_addr, a[15:0]);
            chk(obs_wnr == wr && !wnr_bad, "R4 direction", obs_wnr, wr);
            if (wr) chk(!wd_bad, "R5 write data lanes", wd_bad, 0);
            else    chk(!rd_bad, "R6 read release", rd_bad, 0);
            chk(busy_cnt == exp_busy, to ? "R8 timeout length" : "R7 ready wait length",
                busy_cnt, exp_busy);
            chk(rsp_cnt == 1, "R9 single response", rsp_cnt, 1);
            chk(obs_err == to, to ? "R8 timeout error" : "R8 no error", obs_err, to);
            chk(obs_rdata == exp_rd, wr ? "R6 write returns zero" : "R6 read data",
                obs_rdata, exp_rd);
            chk(!tr_bad, "R11 recovery release", tr_bad, 0);
        end
        chk(!busy, "R9 busy low after response", busy, 0);
        if (poke) begin
            @(negedge clk); #1;
            @(negedge clk); #1;
            chk(!busy && ale_cnt == 1 && rsp_cnt == 1, "R10 request while busy ignored",
                ale_cnt, 1);
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int r;
        logic [23:0] a;
        gap = 0; last_gap = 0;
        clr_obs();
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bus_cs_n == 4'hF && !bus_ale && !bus_ad_oe, "R1 reset selects idle", bus_cs_n, 4'hF);
        chk(!busy && !rsp_valid && !bus_wnr, "R9 reset not busy", busy, 0);

        // Directed corners.
        access({4'd4, 20'h01234}, 1, 16'hA55A, 0, 0);
        access({4'd7, 20'h0BEEF}, 0, 16'h0, TMO + 1, 0);
        access({4'd6, 20'h03210}, 0, 16'h0, TMO + 2, 0);
        access({4'd5, 20'h0F00D}, 1, 16'h1234, TMO + 5, 0);
        access({4'd3, 20'hFFFFF}, 0, 16'h0, 0, 0);
        access({4'd8, 20'h00000}, 1, 16'h7777, 0, 0);
        access({4'd5, 20'hF4321}, 0, 16'h0, 3, 0);
        chk(obs_addr == 16'h4321, "R3 upper window bits alias", obs_addr, 16'h4321);
        access({4'd6, 20'h00010}, 1, 16'h00FF, 4, 1);
        access({4'd4, 20'h00020}, 0, 16'h0, 2, 0);
        access({4'd7, 20'h00030}, 1, 16'hBEEF, 1, 0);
        chk(last_gap == 2, "R11 idle gap between accesses", last_gap, 2);

        // Random mix.
        for (int n = 0; n < 80; n++) begin
            if ($urandom % 8 == 0)
                r = ($urandom % 2 == 1) ? int'($urandom % 4) : 8 + int'($urandom % 8);
            else
                r = 4 + int'($urandom % 4);
            a = {4'(r), 20'($urandom)};
            access(a, 1'($urandom), 16'($urandom), int'($urandom % (TMO + 4)),
                   (r >= 4 && r <= 7) && ($urandom % 6 == 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule